// File: doc/BRIEF.md
# Receive Frame Status and Multicast Filter

This block sits beside an Ethernet receive path and watches the byte stream of each incoming frame. It counts the bytes of the frame and records whether the count is odd, below the shortest legal frame, or above the longest one. While the first six bytes arrive, which are the destination address, it runs the Ethernet CRC-32 over them. The top six bits of that CRC form a hash. The hash picks one bit of a 64-bit group-address table that software supplies as eight bytes.

When the frame's last byte has been taken, the block issues a one-cycle status word. The word carries the accept decision, the group-address flag, the hash, and the three length flags. A group-addressed frame whose table bit is set is always accepted. Every other frame takes its decision from an accept input driven by the rest of the address filter, for example a promiscuous mode or an exact-match unit. Software can reuse the exported hash to speed up its own group lookup.

Top module: `rx_frame_filter`

## Requirements
- R1: `st_valid` is high for exactly the one cycle after the clock edge that takes a frame's last byte (`in_valid` and `in_eof` high), and low otherwise. Bytes with `in_valid` high arriving outside a frame (no `in_sof` since the last `in_eof`) are ignored.
- R2: The frame length is the number of bytes with `in_valid` high from the `in_sof` byte to the `in_eof` byte inclusive. Cycles with `in_valid` low do not count. `st_odd` is 1 when that true length is odd, even when the internal counter has saturated.
- R3: `st_too_short` is 1 when the length is below 64.
- R4: `st_too_long` is 1 when the length exceeds 1518. The length counter saturates at 4095 instead of wrapping, so any longer frame still reports too long.
- R5: `st_mcast` equals bit 0 of the frame's first byte.
- R6: `st_hash` is bits 31..26 of a CRC register run over the first six bytes of the frame, or over fewer bytes if the frame is shorter. The register starts at all ones and uses polynomial 0x04C11DB7. Each byte is shifted in LSB first. No final inversion is applied.
- R7: Table byte k is `mcast_table[8k+7:8k]`. `st_hash[5:3]` picks the byte and `st_hash[2:0]` picks the bit within it. So hash 000000 maps to byte 0 bit 0, 010000 maps to byte 2 bit 0, 100111 maps to byte 4 bit 7, and 111111 maps to byte 7 bit 7.
- R8: `st_accept` is 1 when `other_accept` is high on the last-byte cycle, or when the frame is group-addressed, all six address bytes arrived, and the indexed table bit is 1. A table hit accepts the frame whatever `other_accept` says.
- R9: A frame that ends before its sixth byte never gets a table hit. Its `st_accept` equals `other_accept`.
- R10: An `in_sof` byte arriving inside a frame restarts the length, hash and group-flag tracking from that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_sof | input | 1 | The byte is the first of a frame |
| in_eof | input | 1 | The byte is the last of a frame |
| in_data | input | 8 | Received byte |
| mcast_table | input | 64 | Group-address table, byte k at bits 8k+7..8k |
| other_accept | input | 1 | Accept from the other address-filter criteria, sampled on the last byte |
| st_valid | output | 1 | Status word valid (one cycle) |
| st_accept | output | 1 | Frame passes address filtering |
| st_mcast | output | 1 | Destination address is a group address |
| st_hash | output | 6 | Hash from the destination-address CRC |
| st_odd | output | 1 | Frame has an odd byte count |
| st_too_long | output | 1 | Frame longer than 1518 bytes |
| st_too_short | output | 1 | Frame shorter than 64 bytes |

## Verification
Every status field is due exactly one clock after the edge that takes the `in_eof` byte. Between frames, `st_valid` must be low on every cycle. The bench drives inputs on the falling edge and updates its behavioural model just after the rising edge. It then compares all outputs with the model on the next falling edge, so a result that appears one cycle early or late is caught on every clock. Frames include gaps, out-of-frame bytes, restarts, a saturating length, and addresses searched in the bench so that they land on chosen table bits.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int unsigned DA_BYTES  = 6;
    localparam int unsigned HASH_W    = 6;
    localparam int unsigned CRC_W     = 32;
    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

    typedef struct packed {
        logic              accept;
        logic              mcast;
        logic [HASH_W-1:0] hash;
        logic              odd;
        logic              too_long;
        logic              too_short;
    } rxf_status_t;

    // One byte through the CRC register, least significant data bit first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [7:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[CRC_W-1] ^ d[b]) r = (r << 1) ^ CRC_POLY;
            else                   r = r << 1;
        end
        return r;
    endfunction

    // Byte select from the upper hash bits, bit select from the lower ones.
    function automatic logic table_bit(input logic [63:0] tbl,
                                       input logic [HASH_W-1:0] h);
        logic [7:0] sel;
        sel = tbl[{h[5:3], 3'b000} +: 8];
        return sel[h[2:0]];
    endfunction

endpackage

// File: rtl/rxf_crc_hash.sv
module rxf_crc_hash
    import rxf_pkg::*;
#(
    parameter int unsigned NBYTES = DA_BYTES
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             beat,
    input  logic             start,
    input  logic [7:0]       data,
    output logic [CRC_W-1:0] crc_nxt,
    output logic             da_done_nxt,
    output logic             grp_nxt
);
    localparam int unsigned CW = $clog2(NBYTES + 1);

    logic [CRC_W-1:0] crc_q;
    logic [CW-1:0]    cnt_q, cnt_nxt, base_cnt;
    logic [CRC_W-1:0] base_crc;
    logic             grp_q;

    always_comb begin
        base_crc = start ? CRC_SEED : crc_q;
        base_cnt = start ? '0 : cnt_q;
        crc_nxt  = crc_q;
        cnt_nxt  = cnt_q;
        grp_nxt  = grp_q;
        if (beat) begin
            crc_nxt = base_crc;
            cnt_nxt = base_cnt;
            if (base_cnt < CW'(NBYTES)) begin
                crc_nxt = crc_step(base_crc, data);
                cnt_nxt = base_cnt + 1'b1;
            end
            if (start) grp_nxt = data[0];
        end
        da_done_nxt = (cnt_nxt == CW'(NBYTES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_SEED;
            cnt_q <= '0;
            grp_q <= 1'b0;
        end else begin
            crc_q <= crc_nxt;
            cnt_q <= cnt_nxt;
            grp_q <= grp_nxt;
        end
    end

    // R6: once the address is complete, later bytes leave the CRC alone
    p_crc_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CW'(NBYTES) && !(beat && start)) |=> $stable(crc_q));

    // R6: the address byte count never runs past the address length
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(NBYTES));

endmodule

// File: rtl/rxf_len_track.sv
module rxf_len_track #(
    parameter int unsigned LEN_W = 12
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             beat,
    input  logic             start,
    output logic [LEN_W-1:0] len_nxt,
    output logic             odd_nxt
);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    logic [LEN_W-1:0] len_q, base;
    logic             odd_q;

    always_comb begin
        base    = start ? '0 : len_q;
        len_nxt = len_q;
        odd_nxt = odd_q;
        if (beat) begin
            len_nxt = (base == LEN_MAX) ? base : base + 1'b1;
            odd_nxt = start ? 1'b1 : ~odd_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            odd_q <= 1'b0;
        end else begin
            len_q <= len_nxt;
            odd_q <= odd_nxt;
        end
    end

    // R4: the count only grows inside a frame
    p_len_monotonic_r4: assert property (@(posedge clk) disable iff (rst)
        (!start) |=> len_q >= $past(len_q));

    // R4: a saturated count stays saturated until the next frame starts
    p_len_sat_r4: assert property (@(posedge clk) disable iff (rst)
        (len_q == LEN_MAX && !start) |=> len_q == LEN_MAX);

endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
    import rxf_pkg::*;
#(
    parameter int unsigned LEN_W   = 12,
    parameter int unsigned MIN_LEN = 64,
    parameter int unsigned MAX_LEN = 1518
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [7:0]        in_data,
    input  logic [63:0]       mcast_table,
    input  logic              other_accept,
    output logic              st_valid,
    output logic              st_accept,
    output logic              st_mcast,
    output logic [HASH_W-1:0] st_hash,
    output logic              st_odd,
    output logic              st_too_long,
    output logic              st_too_short
);
    logic             in_frame_q;
    logic             start, beat, last;
    logic [CRC_W-1:0] crc_nxt;
    logic             da_done_nxt, grp_nxt, odd_nxt;
    logic [LEN_W-1:0] len_nxt;
    rxf_status_t      stat_d, stat_q;
    logic             valid_q;

    assign start = in_valid && in_sof;
    assign beat  = in_valid && (in_sof || in_frame_q);
    assign last  = beat && in_eof;

    rxf_crc_hash #(.NBYTES(DA_BYTES)) u_hash (
        .clk(clk), .rst(rst), .beat(beat), .start(start), .data(in_data),
        .crc_nxt(crc_nxt), .da_done_nxt(da_done_nxt), .grp_nxt(grp_nxt)
    );

    rxf_len_track #(.LEN_W(LEN_W)) u_len (
        .clk(clk), .rst(rst), .beat(beat), .start(start),
        .len_nxt(len_nxt), .odd_nxt(odd_nxt)
    );

    always_comb begin
        stat_d.hash      = crc_nxt[CRC_W-1 -: HASH_W];
        stat_d.mcast     = grp_nxt;
        stat_d.odd       = odd_nxt;
        stat_d.too_long  = len_nxt > LEN_W'(MAX_LEN);
        stat_d.too_short = len_nxt < LEN_W'(MIN_LEN);
        stat_d.accept    = other_accept ||
                           (grp_nxt && da_done_nxt &&
                            table_bit(mcast_table, crc_nxt[CRC_W-1 -: HASH_W]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            valid_q    <= 1'b0;
            stat_q     <= '0;
        end else begin
            if (last)       in_frame_q <= 1'b0;
            else if (start) in_frame_q <= 1'b1;
            valid_q <= last;
            if (last) stat_q <= stat_d;
        end
    end

    assign st_valid     = valid_q;
    assign st_accept    = stat_q.accept;
    assign st_mcast     = stat_q.mcast;
    assign st_hash      = stat_q.hash;
    assign st_odd       = stat_q.odd;
    assign st_too_long  = stat_q.too_long;
    assign st_too_short = stat_q.too_short;

    // R1: status pulse follows a last byte taken inside a frame
    p_status_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> $past(in_valid && in_eof && (in_sof || in_frame_q)));

    // R1: status pulse lasts a single cycle unless another frame ended
    p_status_single_r1: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !(in_valid && in_eof)) |=> !st_valid);

    // R8: a rejected frame had no accept from the other criteria
    p_reject_source_r8: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_accept) |-> !$past(other_accept));

    // R3: a frame cannot be both too short and too long
    p_len_flags_excl_r3: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> !(st_too_long && st_too_short));

endmodule

// File: tb/tb_rx_frame_filter.sv
`timescale 1ns/1ps
module tb_rx_frame_filter;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_sof, in_eof, other_accept;
    logic [7:0]  in_data;
    logic [63:0] mcast_table;
    logic        st_valid, st_accept, st_mcast, st_odd, st_too_long, st_too_short;
    logic [5:0]  st_hash;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    rx_frame_filter dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_data(in_data), .mcast_table(mcast_table),
        .other_accept(other_accept), .st_valid(st_valid), .st_accept(st_accept),
        .st_mcast(st_mcast), .st_hash(st_hash), .st_odd(st_odd),
        .st_too_long(st_too_long), .st_too_short(st_too_short)
    );

    // ---------------- behavioural reference ----------------
    bit          m_in;
    int          m_len, m_cnt;
    logic [31:0] m_crc;
    bit          m_grp;
    bit          e_valid, e_accept, e_mcast, e_odd, e_long, e_short;
    logic [5:0]  e_hash;
    string       ctx = "R1";

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r = c;
        for (int b = 0; b < 8; b++) begin
            bit fb = r[31] ^ d[b];
            r = {r[30:0], 1'b0};
            if (fb) r = r ^ 32'h04C11DB7;
        end
        return r;
    endfunction

    function automatic logic [5:0] da_hash(input logic [7:0] da [6]);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < 6; i++) c = ref_crc(c, da[i]);
        return c[31:26];
    endfunction

    task automatic model(input bit v, input bit s, input bit e,
                         input logic [7:0] d, input bit oa);
        e_valid = 0;
        if (v && (s || m_in)) begin
            if (s) begin
                m_len = 0; m_cnt = 0; m_crc = 32'hFFFFFFFF; m_grp = d[0];
            end
            m_len++;
            if (m_cnt < 6) begin m_crc = ref_crc(m_crc, d); m_cnt++; end
            m_in = 1;
            if (e) begin
                int idx;
                e_valid = 1;
                e_hash  = m_crc[31:26];
                idx     = int'(e_hash);
                e_mcast = m_grp;
                e_odd   = (m_len % 2) == 1;
                e_long  = m_len > 1518;
                e_short = m_len < 64;
                e_accept = oa || (m_grp && m_cnt == 6 && mcast_table[idx]);
                m_in = 0;
            end
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s]: actual %0d expected %0d", req, ctx, act, exp);
        end
    endtask

    task automatic compare();
        chk("R1 st_valid", int'(st_valid), int'(e_valid));
        if (e_valid) begin
            chk("R2 st_odd",        int'(st_odd),       int'(e_odd));
            chk("R3 st_too_short",  int'(st_too_short), int'(e_short));
            chk("R4 st_too_long",   int'(st_too_long),  int'(e_long));
            chk("R5 st_mcast",      int'(st_mcast),     int'(e_mcast));
            chk("R6 st_hash",       int'(st_hash),      int'(e_hash));
            chk("R8 st_accept",     int'(st_accept),    int'(e_accept));
        end
    endtask

    task automatic beat(input bit v, input bit s, input bit e,
                        input logic [7:0] d, input bit oa);
        @(negedge clk);
        compare();
        in_valid = v; in_sof = s; in_eof = e; in_data = d; other_accept = oa;
        @(posedge clk);
        #1;
        model(v, s, e, d, oa);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) beat(0, 0, 0, 8'h00, 0);
    endtask

    task automatic frame(input int n, input logic [7:0] da [6], input bit oa,
                         input int gap);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = (i < 6) ? da[i] : 8'((i * 7 + 3) & 255);
            beat(1, i == 0, i == n - 1, d, oa);
            if (gap > 0 && (i % gap) == gap - 1 && i != n - 1) beat(0, 0, 0, 8'hA5, 0);
        end
        idle(2);
    endtask

    // Search for a group address with the wanted hash (bytes 4 and 5 varied).
    task automatic find_da(input logic [5:0] want, output logic [7:0] da [6]);
        da = '{8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h00};
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                da[4] = 8'(a); da[5] = 8'(b);
                if (da_hash(da) == want) return;
            end
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] uc [6];
        logic [7:0] gp [6];
        logic [7:0] dh [6];
        logic [5:0] h;

        uc = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        gp = '{8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01};
        rst = 1; in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0;
        other_accept = 0; mcast_table = '0;
        m_in = 0; m_len = 0; m_cnt = 0; m_crc = '1; m_grp = 0; e_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        ctx = "R1 reset";
        idle(2);

        ctx = "R1 stray bytes outside frame";
        beat(1, 0, 0, 8'h01, 1); beat(1, 0, 1, 8'h01, 1); idle(2);

        ctx = "R2 R3 64-byte unicast";
        frame(64, uc, 1, 0);
        ctx = "R3 63-byte odd short";
        frame(63, uc, 0, 0);
        ctx = "R2 gaps inside frame";
        frame(100, uc, 1, 7);
        ctx = "R4 1518 boundary";
        frame(1518, uc, 0, 0);
        ctx = "R4 1519 too long";
        frame(1519, uc, 0, 0);
        ctx = "R4 R2 saturated 5000";
        frame(5000, uc, 0, 0);

        ctx = "R8 group addr, empty table";
        frame(70, gp, 0, 0);
        h = da_hash(gp);
        ctx = "R8 group addr, table hit overrides";
        mcast_table = 64'h1 << h;
        frame(70, gp, 0, 0);
        ctx = "R8 group addr, other bits only";
        mcast_table = ~(64'h1 << h);
        frame(70, gp, 0, 0);
        ctx = "R8 unicast ignores table";
        mcast_table = '1;
        frame(70, uc, 0, 0);

        ctx = "R7 byte 2 bit 0";
        find_da(6'b010000, dh);
        mcast_table = '0; mcast_table[23:16] = 8'h01;
        frame(66, dh, 0, 0);
        ctx = "R7 byte 4 bit 7";
        find_da(6'b100111, dh);
        mcast_table = '0; mcast_table[39] = 1'b1;
        frame(66, dh, 0, 0);
        ctx = "R7 byte 7 bit 7";
        find_da(6'b111111, dh);
        mcast_table = '0; mcast_table[63] = 1'b1;
        frame(66, dh, 0, 0);
        ctx = "R7 byte 0 bit 0";
        find_da(6'b000000, dh);
        mcast_table = '0; mcast_table[0] = 1'b1;
        frame(66, dh, 0, 0);
        mcast_table[0] = 1'b0; mcast_table[8] = 1'b1;
        frame(66, dh, 0, 0);

        ctx = "R9 short group frame";
        mcast_table = '1;
        frame(3, gp, 0, 0);
        frame(1, gp, 1, 0);
        frame(5, gp, 0, 0);

        ctx = "R10 restart mid frame";
        mcast_table = 64'h1 << h;
        for (int i = 0; i < 20; i++) beat(1, i == 0, 0, uc[i % 6], 0);
        for (int i = 0; i < 65; i++)
            beat(1, i == 0, i == 64, (i < 6) ? gp[i] : 8'h00, 0);
        idle(2);

        ctx = "R1 back-to-back frames";
        for (int i = 0; i < 64; i++) beat(1, i == 0, i == 63, (i < 6) ? gp[i] : 8'h3C, 0);
        for (int i = 0; i < 65; i++) beat(1, i == 0, i == 64, (i < 6) ? uc[i] : 8'h3C, 1);
        idle(3);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule